// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers a bank of level-sensitive interrupt request lines and, for each of two interrupt classes delivered to a processor core (a normal class and a fast class), picks the most urgent request that is both pending and enabled. The chosen source number and its programmed handler address are presented on a request/acknowledge style vectored interface. That interface is held steady until the core acknowledges, after which the next winner is offered.

Software configures every source through a small word-wide register port. Each source has an enable bit, a class bit and a 4-bit priority. It also has a 32-bit handler address, kept in a table protected by an extended Hamming code that corrects one flipped bit and detects two. Software can make any source pending by a register write. A status word reports how many single-bit faults were repaired while fetching handler addresses and whether an uncorrectable fault was seen. An uncorrectable fault makes the block hand out a fixed fallback address. A fault-injection word lets test software corrupt the next stored handler address on purpose.

Register address layout: `cfg_addr = {kind[1:0], index}`. The index selects a source, or a global word when kind is 3.

Top module: `vec_intc`

## Requirements
- R1: Under synchronous active-high reset both request outputs are low. All enables, classes, priorities, software-pending bits, the repair count and the fault flag are zero, so a status read (kind 3, index 0) returns 0.
- R2: A source competes only when it is pending (its input line high or its software-pending bit set) and its enable bit is 1. A pending source with enable 0 never raises a request.
- R3: The class bit of a source (kind 0, bit 1) routes it to the normal interface when 0 and to the fast interface when 1. It never appears on the other interface.
- R4: Within a class the competing source with the numerically smallest priority value (kind 0, bits 7:4) wins. Equal priorities go to the lowest source number.
- R5: While a request output is high and its acknowledge is low, that interface's id and vector stay unchanged, even if a more urgent source becomes pending.
- R6: An acknowledge sampled with the request high drops the request on the next cycle, for at least one cycle. It also clears the software-pending bit of the acknowledged source, which reads back in bit 0 of kind 2 (bit 1 shows the input line).
- R7: Writing kind 2 with data bit 0 set makes that source pending until its acknowledge.
- R8: The vector delivered with a request equals the 32-bit address last written to kind 1 for that source.
- R9: With one codeword bit flipped, the delivered and read-back address is still correct. Each delivery that needed a repair increments the repair count (status bits 7:0, saturating). Writing status with bit 30 set clears the count.
- R10: With two codeword bits flipped, the fixed fallback address is delivered instead and status bit 31 becomes set. It stays set until status is written with bit 31 set.
- R11: Kind 0 reads back enable in bit 0, class in bit 1 and priority in bits 7:4. Kind 3, index 1 arms fault injection: bits 5:0 give a codeword bit (0 to 38) flipped when bit 6 is set, and bits 13:8 give a second bit flipped when bit 14 is set. The flips apply to the next kind 1 write only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_lines | input | N | Level-sensitive interrupt request lines |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | IDX_W+2 | Register address {kind, index} |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr, combinational |
| nrm_req | output | 1 | Normal-class vectored request |
| nrm_id | output | IDX_W | Source number of the normal-class request |
| nrm_vec | output | 32 | Handler address of the normal-class request |
| nrm_ack | input | 1 | Core acknowledge for the normal class |
| fst_req | output | 1 | Fast-class vectored request |
| fst_id | output | IDX_W | Source number of the fast-class request |
| fst_vec | output | 32 | Handler address of the fast-class request |
| fst_ack | input | 1 | Core acknowledge for the fast class |

## Verification
A corrupted priority comparison or a wrong class mask shows up at the first delivery after the bad state: the wrong source number reaches the interface one cycle after the competing sources become pending. A lost or stuck software-pending bit shows within one acknowledge. The source is either never offered or is offered a second time two cycles after its acknowledge, and the kind 2 readback exposes the bit directly. Faults in the code check show on the very delivery that fetches the damaged entry, as a wrong address, an unchanged repair count or an unset fault flag.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;

    localparam int DATA_W = 32;
    localparam int PAR_W  = 6;
    localparam int CW_W   = 39;

    typedef logic [CW_W-1:0] cw_t;

    typedef enum logic [1:0] {
        RK_CTRL  = 2'd0,
        RK_VEC   = 2'd1,
        RK_SWSET = 2'd2,
        RK_GLOB  = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic [3:0] prio;
        logic       fast;
        logic       en;
    } src_cfg_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              sec;
        logic              ded;
    } ecc_res_t;

    // Position 0 holds overall parity; powers of two hold Hamming parity.
    function automatic cw_t ecc_encode(input logic [DATA_W-1:0] d);
        cw_t cw;
        int  k;
        logic x;
        cw = '0;
        k  = 0;
        for (int pos = 1; pos < CW_W; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                cw[pos] = d[k];
                k++;
            end
        end
        for (int p = 0; p < PAR_W; p++) begin
            x = 1'b0;
            for (int pos = 1; pos < CW_W; pos++) begin
                if ((((pos >> p) & 1) == 1) && (pos != (1 << p))) x = x ^ cw[pos];
            end
            cw[1 << p] = x;
        end
        cw[0] = ^cw[CW_W-1:1];
        return cw;
    endfunction

    function automatic ecc_res_t ecc_decode(input cw_t cw_in);
        cw_t        cw;
        logic [5:0] syn;
        logic       ovr;
        ecc_res_t   r;
        int         k;
        cw  = cw_in;
        syn = '0;
        for (int p = 0; p < PAR_W; p++) begin
            for (int pos = 1; pos < CW_W; pos++) begin
                if (((pos >> p) & 1) == 1) syn[p] = syn[p] ^ cw[pos];
            end
        end
        ovr   = ^cw;
        r.sec = 1'b0;
        r.ded = 1'b0;
        if (ovr) begin
            if (int'(syn) < CW_W) begin
                r.sec = 1'b1;
                cw[syn] = ~cw[syn];
            end else begin
                r.ded = 1'b1;
            end
        end else if (syn != '0) begin
            r.ded = 1'b1;
        end
        k = 0;
        r.data = '0;
        for (int pos = 1; pos < CW_W; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                r.data[k] = cw[pos];
                k++;
            end
        end
        return r;
    endfunction

    function automatic cw_t inj_mask_from(input logic [31:0] w);
        cw_t m;
        m = '0;
        if (w[6]  && (int'(w[5:0])  < CW_W)) m[w[5:0]]  = 1'b1;
        if (w[14] && (int'(w[13:8]) < CW_W)) m[w[13:8]] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/vec_intc_table.sv
module vec_intc_table
    import vec_intc_pkg::*;
#(
    parameter int N     = 32,
    parameter int IDX_W = 5,
    parameter int NRD   = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [IDX_W-1:0]          waddr,
    input  logic [DATA_W-1:0]         wdata,
    input  cw_t                       flip,
    input  logic [NRD-1:0][IDX_W-1:0] rd_idx,
    output ecc_res_t [NRD-1:0]        rd_res
);

    cw_t mem [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= ecc_encode(wdata) ^ flip;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_res[g] = ecc_decode(mem[rd_idx[g]]);
    end

endmodule

// File: rtl/vec_intc_arb.sv
module vec_intc_arb #(
    parameter int N     = 32,
    parameter int IDX_W = 5
) (
    input  logic [N-1:0]        req,
    input  logic [N-1:0][3:0]   prio,
    output logic                win_valid,
    output logic [IDX_W-1:0]    win_idx
);

    logic [3:0] best_p;

    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        best_p    = '1;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!win_valid || (prio[i] < best_p))) begin
                win_valid = 1'b1;
                best_p    = prio[i];
                win_idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/vec_intc_port.sv
module vec_intc_port
    import vec_intc_pkg::*;
#(
    parameter int          IDX_W       = 5,
    parameter logic [31:0] DEFAULT_VEC = 32'h0000_FFF0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             win_valid,
    input  logic [IDX_W-1:0] win_idx,
    input  ecc_res_t         look,
    input  logic             ack,
    output logic             req,
    output logic [IDX_W-1:0] id,
    output logic [31:0]      vec,
    output logic             sec_evt,
    output logic             ded_evt,
    output logic             clr_valid,
    output logic [IDX_W-1:0] clr_idx
);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] id;
        logic [31:0]      vec;
    } hold_t;

    hold_t h;
    logic  take;

    assign take = !h.busy && win_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            h <= '0;
        end else if (take) begin
            h.busy <= 1'b1;
            h.id   <= win_idx;
            h.vec  <= look.ded ? DEFAULT_VEC : look.data;
        end else if (h.busy && ack) begin
            h.busy <= 1'b0;
        end
    end

    assign req       = h.busy;
    assign id        = h.id;
    assign vec       = h.vec;
    assign sec_evt   = take && look.sec;
    assign ded_evt   = take && look.ded;
    assign clr_valid = h.busy && ack;
    assign clr_idx   = h.id;

endmodule

// File: rtl/vec_intc.sv
module vec_intc
    import vec_intc_pkg::*;
#(
    parameter int          N           = 32,
    parameter int          CNT_W       = 8,
    parameter logic [31:0] DEFAULT_VEC = 32'h0000_FFF0,
    localparam int         IDX_W       = $clog2(N),
    localparam int         ADDR_W      = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      irq_lines,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              nrm_req,
    output logic [IDX_W-1:0]  nrm_id,
    output logic [31:0]       nrm_vec,
    input  logic              nrm_ack,
    output logic              fst_req,
    output logic [IDX_W-1:0]  fst_id,
    output logic [31:0]       fst_vec,
    input  logic              fst_ack
);

    localparam int NCLS = 2;
    localparam int NRD  = NCLS + 1;

    src_cfg_t [N-1:0]       cfg_q;
    logic [N-1:0]           sw_pend;
    logic [CNT_W-1:0]       corr_cnt;
    logic                   ded_sticky;
    cw_t                    inj_q;

    logic [N-1:0]           en_vec;
    logic [N-1:0]           fast_vec;
    logic [N-1:0][3:0]      prio_vec;
    logic [N-1:0]           pend;

    reg_kind_e              kind;
    logic [IDX_W-1:0]       ridx;
    logic                   idx_ok;

    logic [NCLS-1:0][N-1:0]     cls_req;
    logic [NCLS-1:0]            win_v;
    logic [NCLS-1:0][IDX_W-1:0] win_i;
    logic [NCLS-1:0]            p_req;
    logic [NCLS-1:0][IDX_W-1:0] p_id;
    logic [NCLS-1:0][31:0]      p_vec;
    logic [NCLS-1:0]            p_ack;
    logic [NCLS-1:0]            sec_evt;
    logic [NCLS-1:0]            ded_evt;
    logic [NCLS-1:0]            clr_v;
    logic [NCLS-1:0][IDX_W-1:0] clr_i;

    logic [NRD-1:0][IDX_W-1:0]  rd_idx;
    ecc_res_t [NRD-1:0]         rd_res;

    logic [CNT_W:0]         cnt_sum;
    logic [CNT_W-1:0]       cnt_next;

    logic wr_ctrl, wr_vec, wr_sw, wr_stat, wr_inj;

    assign kind   = reg_kind_e'(cfg_addr[ADDR_W-1 -: 2]);
    assign ridx   = cfg_addr[IDX_W-1:0];
    assign idx_ok = int'(ridx) < N;

    assign wr_ctrl = cfg_we && (kind == RK_CTRL)  && idx_ok;
    assign wr_vec  = cfg_we && (kind == RK_VEC)   && idx_ok;
    assign wr_sw   = cfg_we && (kind == RK_SWSET) && idx_ok && cfg_wdata[0];
    assign wr_stat = cfg_we && (kind == RK_GLOB)  && (ridx == IDX_W'(0));
    assign wr_inj  = cfg_we && (kind == RK_GLOB)  && (ridx == IDX_W'(1));

    always_comb begin
        for (int i = 0; i < N; i++) begin
            en_vec[i]   = cfg_q[i].en;
            fast_vec[i] = cfg_q[i].fast;
            prio_vec[i] = cfg_q[i].prio;
        end
    end

    assign pend = irq_lines | sw_pend;

    assign p_ack[0] = nrm_ack;
    assign p_ack[1] = fst_ack;

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        if (c == 0) begin : g_nrm
            assign cls_req[c] = pend & en_vec & ~fast_vec;
        end else begin : g_fst
            assign cls_req[c] = pend & en_vec & fast_vec;
        end

        vec_intc_arb #(.N(N), .IDX_W(IDX_W)) u_arb (
            .req       (cls_req[c]),
            .prio      (prio_vec),
            .win_valid (win_v[c]),
            .win_idx   (win_i[c])
        );

        assign rd_idx[c] = win_i[c];

        vec_intc_port #(.IDX_W(IDX_W), .DEFAULT_VEC(DEFAULT_VEC)) u_port (
            .clk       (clk),
            .rst       (rst),
            .win_valid (win_v[c]),
            .win_idx   (win_i[c]),
            .look      (rd_res[c]),
            .ack       (p_ack[c]),
            .req       (p_req[c]),
            .id        (p_id[c]),
            .vec       (p_vec[c]),
            .sec_evt   (sec_evt[c]),
            .ded_evt   (ded_evt[c]),
            .clr_valid (clr_v[c]),
            .clr_idx   (clr_i[c])
        );
    end

    assign rd_idx[NRD-1] = ridx;

    vec_intc_table #(.N(N), .IDX_W(IDX_W), .NRD(NRD)) u_table (
        .clk    (clk),
        .rst    (rst),
        .we     (wr_vec),
        .waddr  (ridx),
        .wdata  (cfg_wdata),
        .flip   (inj_q),
        .rd_idx (rd_idx),
        .rd_res (rd_res)
    );

    assign nrm_req = p_req[0];
    assign nrm_id  = p_id[0];
    assign nrm_vec = p_vec[0];
    assign fst_req = p_req[1];
    assign fst_id  = p_id[1];
    assign fst_vec = p_vec[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_ctrl) begin
            cfg_q[ridx].en   <= cfg_wdata[0];
            cfg_q[ridx].fast <= cfg_wdata[1];
            cfg_q[ridx].prio <= cfg_wdata[7:4];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_pend <= '0;
        end else begin
            for (int c = 0; c < NCLS; c++) begin
                if (clr_v[c]) sw_pend[clr_i[c]] <= 1'b0;
            end
            if (wr_sw) sw_pend[ridx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            inj_q <= '0;
        end else if (wr_inj) begin
            inj_q <= inj_mask_from(cfg_wdata);
        end else if (wr_vec) begin
            inj_q <= '0;
        end
    end

    always_comb begin
        cnt_sum = {1'b0, corr_cnt} + (CNT_W+1)'(sec_evt[0]) + (CNT_W+1)'(sec_evt[1]);
        cnt_next = cnt_sum[CNT_W] ? '1 : cnt_sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            corr_cnt   <= '0;
            ded_sticky <= 1'b0;
        end else begin
            if (wr_stat && cfg_wdata[30]) corr_cnt <= '0;
            else                          corr_cnt <= cnt_next;
            if (|ded_evt)                        ded_sticky <= 1'b1;
            else if (wr_stat && cfg_wdata[31])   ded_sticky <= 1'b0;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (kind)
            RK_CTRL: if (idx_ok) cfg_rdata = {24'd0, cfg_q[ridx].prio, 2'b00,
                                              cfg_q[ridx].fast, cfg_q[ridx].en};
            RK_VEC: if (idx_ok) cfg_rdata = rd_res[NRD-1].ded ? DEFAULT_VEC
                                                               : rd_res[NRD-1].data;
            RK_SWSET: if (idx_ok) cfg_rdata = {30'd0, irq_lines[ridx], sw_pend[ridx]};
            RK_GLOB: if (ridx == IDX_W'(0)) cfg_rdata = {ded_sticky, (31-CNT_W)'(0), corr_cnt};
            default: cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk #(
    parameter int N      = 32,
    parameter int CNT_W  = 8,
    parameter int IDX_W  = $clog2(N),
    parameter int ADDR_W = IDX_W + 2
) (
    input logic              clk,
    input logic              rst,
    input logic              nrm_req,
    input logic              nrm_ack,
    input logic [IDX_W-1:0]  nrm_id,
    input logic [31:0]       nrm_vec,
    input logic              fst_req,
    input logic              fst_ack,
    input logic [IDX_W-1:0]  fst_id,
    input logic [31:0]       fst_vec,
    input logic [N-1:0]      en_vec,
    input logic [N-1:0]      fast_vec,
    input logic              ded_sticky,
    input logic [CNT_W-1:0]  corr_cnt,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [31:0]       cfg_wdata
);

    logic [N-1:0] en_prev;
    logic [N-1:0] fast_prev;
    logic         stat_wr;

    always_ff @(posedge clk) begin
        en_prev   <= en_vec;
        fast_prev <= fast_vec;
    end

    assign stat_wr = cfg_we && (cfg_addr[ADDR_W-1 -: 2] == 2'd3) &&
                     (cfg_addr[IDX_W-1:0] == IDX_W'(0));

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!nrm_req && !fst_req));

    p_nrm_enabled_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(nrm_req) |-> en_prev[nrm_id]);

    p_fst_enabled_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(fst_req) |-> en_prev[fst_id]);

    p_nrm_class_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(nrm_req) |-> !fast_prev[nrm_id]);

    p_fst_class_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(fst_req) |-> fast_prev[fst_id]);

    p_nrm_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (nrm_req && !nrm_ack) |=> (nrm_req && $stable(nrm_id) && $stable(nrm_vec)));

    p_fst_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (fst_req && !fst_ack) |=> (fst_req && $stable(fst_id) && $stable(fst_vec)));

    p_nrm_ack_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (nrm_req && nrm_ack) |=> !nrm_req);

    p_fst_ack_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (fst_req && fst_ack) |=> !fst_req);

    p_cnt_monotonic_r9: assert property (@(posedge clk) disable iff (rst)
        !(stat_wr && cfg_wdata[30]) |=> (corr_cnt >= $past(corr_cnt)));

    p_ded_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (ded_sticky && !(stat_wr && cfg_wdata[31])) |=> ded_sticky);

endmodule

bind vec_intc vec_intc_chk #(.N(N), .CNT_W(CNT_W)) u_vec_intc_chk (
    .clk        (clk),
    .rst        (rst),
    .nrm_req    (nrm_req),
    .nrm_ack    (nrm_ack),
    .nrm_id     (nrm_id),
    .nrm_vec    (nrm_vec),
    .fst_req    (fst_req),
    .fst_ack    (fst_ack),
    .fst_id     (fst_id),
    .fst_vec    (fst_vec),
    .en_vec     (en_vec),
    .fast_vec   (fast_vec),
    .ded_sticky (ded_sticky),
    .corr_cnt   (corr_cnt),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata)
);

// File: tb/vec_intc_bench.sv
module vec_intc_bench;

    localparam int          N       = 32;
    localparam int          IDX_W   = 5;
    localparam int          ADDR_W  = 7;
    localparam logic [31:0] DEF_VEC = 32'h0000_FFF0;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N-1:0]      irq_lines = '0;
    logic              cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;
    logic              nrm_req, fst_req;
    logic [IDX_W-1:0]  nrm_id, fst_id;
    logic [31:0]       nrm_vec, fst_vec;
    logic              nrm_ack = 1'b0;
    logic              fst_ack = 1'b0;

    vec_intc #(.N(N), .CNT_W(8), .DEFAULT_VEC(DEF_VEC)) u_vec_intc (
        .clk(clk), .rst(rst), .irq_lines(irq_lines),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .nrm_req(nrm_req), .nrm_id(nrm_id), .nrm_vec(nrm_vec), .nrm_ack(nrm_ack),
        .fst_req(fst_req), .fst_id(fst_id), .fst_vec(fst_vec), .fst_ack(fst_ack)
    );

    always #5 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct {
        int          id;
        logic [31:0] vec;
        string       tag;
    } exp_t;

    exp_t q_n[$];
    exp_t q_f[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic expect_irq(input bit f, input int id, input logic [31:0] v, input string tag);
        exp_t e;
        e.id = id; e.vec = v; e.tag = tag;
        if (f) q_f.push_back(e);
        else   q_n.push_back(e);
    endtask

    task automatic score(input bit f);
        exp_t        e;
        logic [31:0] aid;
        logic [31:0] avec;
        aid  = f ? 32'(fst_id) : 32'(nrm_id);
        avec = f ? fst_vec : nrm_vec;
        if ((f ? q_f.size() : q_n.size()) == 0) begin
            check(1'b0, "R2", "unexpected request, id", aid, 32'hFFFF_FFFF);
        end else begin
            e = f ? q_f.pop_front() : q_n.pop_front();
            check(aid == 32'(e.id), e.tag, "delivered id", aid, 32'(e.id));
            check(avec == e.vec, e.tag, "delivered vector", avec, e.vec);
        end
    endtask

    // monitor: compares each new request against the scoreboard
    initial begin
        bit prev_n, prev_f;
        prev_n = 0; prev_f = 0;
        forever begin
            @(negedge clk);
            if (!rst && nrm_req && !prev_n) score(1'b0);
            if (!rst && fst_req && !prev_f) score(1'b1);
            prev_n = nrm_req;
            prev_f = fst_req;
        end
    end

    task automatic wr(input logic [1:0] kind, input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = {kind, IDX_W'(idx)};
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] kind, input int idx, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = {kind, IDX_W'(idx)};
        #1 d = cfg_rdata;
    endtask

    task automatic program_src(input int idx, input bit en, input bit f,
                               input logic [3:0] pr, input logic [31:0] v);
        wr(2'd0, idx, {24'd0, pr, 2'b00, f, en});
        wr(2'd1, idx, v);
    endtask

    task automatic wait_req(input bit f, input string tag);
        int t = 0;
        while (!(f ? fst_req : nrm_req)) begin
            @(negedge clk);
            t++;
            if (t > 200) begin
                check(1'b0, tag, "request timeout", 32'd0, 32'd1);
                return;
            end
        end
        @(negedge clk);
    endtask

    task automatic ack(input bit f);
        @(negedge clk);
        if (f) fst_ack = 1'b1; else nrm_ack = 1'b1;
        @(negedge clk);
        fst_ack = 1'b0;
        nrm_ack = 1'b0;
        check(!(f ? fst_req : nrm_req), "R6", "request low after acknowledge",
              32'(f ? fst_req : nrm_req), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "WD", "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(!nrm_req && !fst_req, "R1", "requests after reset", 32'({nrm_req, fst_req}), 32'd0);
        rd(2'd3, 0, d);
        check(d == 32'd0, "R1", "status after reset", d, 32'd0);
        rd(2'd0, 3, d);
        check(d == 32'd0, "R1", "control after reset", d, 32'd0);

        // R11 readback, R8 vector
        program_src(3, 1'b1, 1'b0, 4'd5, 32'h1000_0300);
        rd(2'd0, 3, d);
        check(d == 32'h0000_0051, "R11", "control readback", d, 32'h0000_0051);
        rd(2'd1, 3, d);
        check(d == 32'h1000_0300, "R8", "vector readback", d, 32'h1000_0300);

        // R7 software pending, R6 clear on acknowledge
        expect_irq(1'b0, 3, 32'h1000_0300, "R7");
        wr(2'd2, 3, 32'd1);
        wait_req(1'b0, "R7");
        rd(2'd2, 3, d);
        check(d == 32'd1, "R7", "software pending readback", d, 32'd1);
        ack(1'b0);
        rd(2'd2, 3, d);
        check(d == 32'd0, "R6", "software pending cleared", d, 32'd0);
        repeat (4) @(negedge clk);
        check(!nrm_req, "R6", "no repeat after acknowledge", 32'(nrm_req), 32'd0);

        // R2 disabled source ignored
        program_src(5, 1'b0, 1'b0, 4'd2, 32'h2000_0500);
        irq_lines[5] = 1'b1;
        repeat (10) @(negedge clk);
        check(!nrm_req && !fst_req, "R2", "disabled source requested",
              32'({nrm_req, fst_req}), 32'd0);
        expect_irq(1'b0, 5, 32'h2000_0500, "R2");
        wr(2'd0, 5, 32'h0000_0021);
        wait_req(1'b0, "R2");
        irq_lines[5] = 1'b0;
        ack(1'b0);

        // R3 fast class routing
        program_src(7, 1'b1, 1'b1, 4'd2, 32'h3000_0700);
        expect_irq(1'b1, 7, 32'h3000_0700, "R3");
        wr(2'd2, 7, 32'd1);
        wait_req(1'b1, "R3");
        check(!nrm_req, "R3", "fast source on normal interface", 32'(nrm_req), 32'd0);
        ack(1'b1);

        // R4 priority order with tie on lowest number
        program_src(10, 1'b1, 1'b0, 4'd3, 32'h4000_0A00);
        program_src(12, 1'b1, 1'b0, 4'd1, 32'h4000_0C00);
        program_src(14, 1'b1, 1'b0, 4'd1, 32'h4000_0E00);
        expect_irq(1'b0, 12, 32'h4000_0C00, "R4");
        @(negedge clk);
        irq_lines[10] = 1'b1; irq_lines[12] = 1'b1; irq_lines[14] = 1'b1;
        wait_req(1'b0, "R4");
        expect_irq(1'b0, 14, 32'h4000_0E00, "R4");
        irq_lines[12] = 1'b0;
        ack(1'b0);
        wait_req(1'b0, "R4");
        expect_irq(1'b0, 10, 32'h4000_0A00, "R4");
        irq_lines[14] = 1'b0;
        ack(1'b0);
        wait_req(1'b0, "R4");
        irq_lines[10] = 1'b0;
        ack(1'b0);

        // R5 hold while unacknowledged
        program_src(20, 1'b1, 1'b0, 4'd8, 32'h5000_1400);
        program_src(21, 1'b1, 1'b0, 4'd0, 32'h5000_1500);
        expect_irq(1'b0, 20, 32'h5000_1400, "R5");
        irq_lines[20] = 1'b1;
        wait_req(1'b0, "R5");
        irq_lines[21] = 1'b1;
        repeat (5) @(negedge clk);
        check(nrm_req && nrm_id == IDX_W'(20), "R5", "held id", 32'(nrm_id), 32'd20);
        check(nrm_vec == 32'h5000_1400, "R5", "held vector", nrm_vec, 32'h5000_1400);
        expect_irq(1'b0, 21, 32'h5000_1500, "R5");
        irq_lines[20] = 1'b0;
        ack(1'b0);
        wait_req(1'b0, "R5");
        irq_lines[21] = 1'b0;
        ack(1'b0);

        // both classes at once
        program_src(1, 1'b1, 1'b0, 4'd4, 32'h6000_0100);
        program_src(2, 1'b1, 1'b1, 4'd4, 32'h6000_0200);
        expect_irq(1'b0, 1, 32'h6000_0100, "R3");
        expect_irq(1'b1, 2, 32'h6000_0200, "R3");
        @(negedge clk);
        irq_lines[1] = 1'b1; irq_lines[2] = 1'b1;
        wait_req(1'b0, "R3");
        wait_req(1'b1, "R3");
        irq_lines[1] = 1'b0; irq_lines[2] = 1'b0;
        ack(1'b0);
        ack(1'b1);

        // R9 single flipped bit repaired and counted
        wr(2'd3, 1, 32'h0000_0043);
        program_src(4, 1'b1, 1'b0, 4'd6, 32'hABCD_1234);
        rd(2'd1, 4, d);
        check(d == 32'hABCD_1234, "R9", "repaired readback", d, 32'hABCD_1234);
        expect_irq(1'b0, 4, 32'hABCD_1234, "R9");
        wr(2'd2, 4, 32'd1);
        wait_req(1'b0, "R9");
        ack(1'b0);
        rd(2'd3, 0, d);
        check(d == 32'h0000_0001, "R9", "status after repair", d, 32'h0000_0001);

        // R10 double flip gives fallback and sticky flag
        wr(2'd3, 1, 32'h0000_4945);
        program_src(6, 1'b1, 1'b0, 4'd6, 32'h5555_AAAA);
        expect_irq(1'b0, 6, DEF_VEC, "R10");
        wr(2'd2, 6, 32'd1);
        wait_req(1'b0, "R10");
        ack(1'b0);
        rd(2'd3, 0, d);
        check(d == 32'h8000_0001, "R10", "status after double fault", d, 32'h8000_0001);
        repeat (3) @(negedge clk);
        rd(2'd3, 0, d);
        check(d[31], "R10", "flag stays set", d, 32'h8000_0001);
        wr(2'd3, 0, 32'h8000_0000);
        rd(2'd3, 0, d);
        check(d == 32'h0000_0001, "R10", "status after flag clear", d, 32'h0000_0001);
        wr(2'd3, 0, 32'h4000_0000);
        rd(2'd3, 0, d);
        check(d == 32'h0000_0000, "R9", "status after count clear", d, 32'h0000_0000);

        repeat (5) @(negedge clk);
        check(q_n.size() == 0, "R8", "normal deliveries missing", 32'(q_n.size()), 32'd0);
        check(q_f.size() == 0, "R8", "fast deliveries missing", 32'(q_f.size()), 32'd0);
        finish_run();
    end

endmodule